// File: doc/BRIEF.md
# Dual Phase-Delayed Square-Wave Generator

This block takes an external square-wave reference and produces two outputs. Each output is a copy of the reference, delayed by its own programmable number of clock ticks. A single up-counter restarts at every reference edge. A two-phase state machine records whether the reference is in its high half or its low half. In each channel, a comparator drives the output high when the counter reaches the channel's delay during the high half, and drives it low when the counter reaches that delay during the low half. The result is a phase shift, not a duty-cycle change.

Software programs a delay for each channel through a small write port. The write port holds two reload registers and a run bit. A reload value becomes the channel's active delay only when the counter next restarts on a reference edge, so the current half-period always finishes with a consistent value. The block comes out of reset halted, and nothing moves until the run bit is set.

Top module: `phase_pwm_top`

## Requirements
- R1: Reset leaves both outputs low, the phase state in the low phase, the counter at zero, the run bit clear, and both reload and active delay registers at zero.
- R2: While the run bit (bit 0 of address 0) is clear, the reference is ignored: the counter, the phase state and both outputs keep their values.
- R3: The reference passes through a two-flop synchronizer. A reference transition restarts the counter at the third rising clock edge after it. The output then reacts at the clock edge after the counter equals the delay, so an output follows the reference `delay + 4` clocks later when sampled between clock edges.
- R4: In the low phase, a rising reference edge restarts the counter at zero and moves the machine to the high phase.
- R5: In the high phase, a falling reference edge restarts the counter at zero and moves the machine to the low phase.
- R6: Channel A (`out_a`) goes high when the counter equals its active delay in the high phase, and goes low when the counter equals that delay in the low phase.
- R7: Channel B (`out_b`) behaves the same way as channel A, using its own delay.
- R8: Writes to address 1 (channel A reload) and address 2 (channel B reload) change the active delay only at the next counter restart. A write made partway through a half-period does not alter that half-period.
- R9: A delay at or above the number of clocks in a half-period is never matched, so that output does not change.
- R10: The counter is a single 32-bit count. A delay above 65535 is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous square-wave reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 = control, 1 = reload A, 2 = reload B |
| wr_data | input | 32 | Register write data |
| out_a | output | 1 | Delayed copy of the reference, channel A |
| out_b | output | 1 | Delayed copy of the reference, channel B |

## Verification
The delay function is exercised with square waves of several half-period lengths. A per-cycle model compares each output against the reference shifted by `delay + 4` clocks.

The delays are chosen to separate distinct behaviours:
- A zero delay checks the earliest possible response.
- A mid-range delay checks ordinary operation.
- A delay of one less than the half-period puts the match in the same cycle as the restart, which exposes whether the old or the new phase is used.
- Delays at or beyond the half-period must leave the output untouched.

Directed runs cover the remaining behaviours:
- Toggling the reference while halted.
- Reload writes made just before, and partway through, a half-period, to show they take effect only at the next edge.
- A delay above 65535, which a narrow counter would miss.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;

    localparam int NCH    = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_RELOAD_0 = 2'd1;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t find_edges(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic [ADDR_W-1:0] reload_addr(input int ch);
        return ADR_RELOAD_0 + ADDR_W'(ch);
    endfunction

endpackage

// File: rtl/ref_sync.sv
module ref_sync
    import phase_pwm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_in,
    output edge_t edges
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ref_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign edges = find_edges(sync_q[STAGES-1], last_q);

endmodule

// File: rtl/phase_counter.sv
module phase_counter
    import phase_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  edge_t            edges,
    output phase_e           state,
    output logic [CNT_W-1:0] cnt,
    output logic             restart
);
    phase_e           state_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        restart = 1'b0;
        if (run) begin
            unique case (state_q)
                PH_LOW:  restart = edges.rise;
                PH_HIGH: restart = edges.fall;
                default: restart = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_LOW;
            cnt_q   <= '0;
        end else if (run) begin
            if (restart) begin
                cnt_q   <= '0;
                state_q <= (state_q == PH_LOW) ? PH_HIGH : PH_LOW;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign state = state_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import phase_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    output logic                      run,
    output logic [NCH-1:0][CNT_W-1:0] reload
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
        end else if (wr_en && wr_addr == ADR_CTRL) begin
            run <= wr_data[0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_reload
        always_ff @(posedge clk) begin
            if (rst) begin
                reload[g] <= '0;
            end else if (wr_en && wr_addr == reload_addr(g)) begin
                reload[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/match_channel.sv
module match_channel
    import phase_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  phase_e           state,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] match,
    output logic             out
);
    logic hit;

    assign hit = run && (cnt == match);

    always_ff @(posedge clk) begin
        if (rst) begin
            match <= '0;
            out   <= 1'b0;
        end else begin
            if (restart) begin
                match <= reload;
            end
            if (hit) begin
                out <= (state == PH_HIGH);
            end
        end
    end

endmodule

// File: rtl/phase_pwm_top.sv
module phase_pwm_top
    import phase_pwm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              out_a,
    output logic              out_b
);
    edge_t                     edges;
    phase_e                    state_q;
    logic [CNT_W-1:0]          cnt_q;
    logic                      restart;
    logic                      run_q;
    logic [NCH-1:0][CNT_W-1:0] reload_q;
    logic [NCH-1:0][CNT_W-1:0] match_q;
    logic [NCH-1:0]            out_q;

    ref_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .edges  (edges)
    );

    cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run     (run_q),
        .reload  (reload_q)
    );

    phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .edges   (edges),
        .state   (state_q),
        .cnt     (cnt_q),
        .restart (restart)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        match_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .run     (run_q),
            .restart (restart),
            .state   (state_q),
            .cnt     (cnt_q),
            .reload  (reload_q[g]),
            .match   (match_q[g]),
            .out     (out_q[g])
        );
    end

    assign out_a = out_q[0];
    assign out_b = out_q[1];

endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk
    import phase_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input phase_e           state,
    input logic [CNT_W-1:0] cnt,
    input edge_t            edges,
    input logic [CNT_W-1:0] match_a,
    input logic [CNT_W-1:0] match_b,
    input logic [CNT_W-1:0] reload_a,
    input logic             out_a,
    input logic             out_b
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_a && !out_b && cnt == '0 && state == PH_LOW && !run));

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(out_a) && $stable(out_b) && $stable(cnt) && $stable(state)));

    p_rise_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (run && state == PH_LOW && edges.rise) |=> (state == PH_HIGH && cnt == '0));

    p_fall_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (run && state == PH_HIGH && edges.fall) |=> (state == PH_LOW && cnt == '0));

    p_a_high_r6: assert property (@(posedge clk) disable iff (rst)
        (run && state == PH_HIGH && cnt == match_a) |=> out_a);

    p_a_low_r6: assert property (@(posedge clk) disable iff (rst)
        (run && state == PH_LOW && cnt == match_a) |=> !out_a);

    p_b_high_r7: assert property (@(posedge clk) disable iff (rst)
        (run && state == PH_HIGH && cnt == match_b) |=> out_b);

    p_b_low_r7: assert property (@(posedge clk) disable iff (rst)
        (run && state == PH_LOW && cnt == match_b) |=> !out_b);

    p_reload_copy_r8: assert property (@(posedge clk) disable iff (rst)
        (run && ((state == PH_LOW && edges.rise) || (state == PH_HIGH && edges.fall)))
        |=> (match_a == $past(reload_a)));

    p_match_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!edges.rise && !edges.fall) |=> $stable(match_a));

endmodule

bind phase_pwm_top phase_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .state    (state_q),
    .cnt      (cnt_q),
    .edges    (edges),
    .match_a  (match_q[0]),
    .match_b  (match_q[1]),
    .reload_a (reload_q[0]),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/test_phase_pwm_top.sv
module test_phase_pwm_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG       = 150000;
    localparam int  NVEC       = 5;
    // half-period, delay A, delay B
    localparam int  VEC [NVEC][3] = '{
        '{10, 0, 4},
        '{10, 9, 2},
        '{8, 8, 7},
        '{16, 7, 15},
        '{12, 30, 11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        out_a;
    logic        out_b;

    int n_checks = 0;
    int n_fail   = 0;
    int nk       = 0;
    logic hist [0:1023];

    phase_pwm_top i_phase_pwm_top (
        .clk     (clk),
        .rst     (rst),
        .ref_in  (ref_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .out_a   (out_a),
        .out_b   (out_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
        nk++;
    endtask

    task automatic run_to(input int target);
        while (nk < target) tick();
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at step %0d: actual %b expected %b", req, nk, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        ref_in = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 out_a after reset", out_a, 1'b0);
        check("R1 out_b after reset", out_b, 1'b0);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n0;

        // Table of waveforms: R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            int h;
            int ma;
            int mb;
            h  = VEC[v][0];
            ma = VEC[v][1];
            mb = VEC[v][2];
            do_reset();
            wr(2'd1, 32'(ma));
            wr(2'd2, 32'(mb));
            wr(2'd0, 32'd1);
            for (int k = 0; k < 8 * h; k++) begin
                logic ea;
                logic eb;
                tick();
                ea = (ma < h && k >= ma + 4) ? hist[k - ma - 4] : 1'b0;
                eb = (mb < h && k >= mb + 4) ? hist[k - mb - 4] : 1'b0;
                check("R6 R3 R9 out_a delayed copy", out_a, ea);
                check("R7 R3 R9 out_b delayed copy", out_b, eb);
                ref_in  = ((k / h) % 2) == 0;
                hist[k] = ref_in;
            end
        end

        // R2: halted block ignores the reference
        do_reset();
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd1);
        n0 = nk;
        ref_in = 1'b1;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (k == 10) ref_in = 1'b0;
            check("R2 out_a while halted", out_a, 1'b0);
            check("R2 out_b while halted", out_b, 1'b0);
        end
        wr(2'd0, 32'd1);
        tick();
        n0 = nk;
        ref_in = 1'b1;
        run_to(n0 + 4);
        check("R3 out_a one tick before delay", out_a, 1'b0);
        run_to(n0 + 5);
        check("R3 out_a at delay+4", out_a, 1'b1);

        // R8: reload timing
        do_reset();
        wr(2'd1, 32'd5);
        wr(2'd0, 32'd1);
        tick();
        n0 = nk;
        ref_in = 1'b1;
        run_to(n0 + 8);
        check("R8 out_a before first delay", out_a, 1'b0);
        run_to(n0 + 9);
        check("R8 out_a with delay 5", out_a, 1'b1);
        run_to(n0 + 20);
        wr(2'd1, 32'd9);
        run_to(n0 + 30);
        ref_in = 1'b0;
        run_to(n0 + 35);
        wr(2'd1, 32'd2);
        run_to(n0 + 42);
        check("R8 out_a held, mid-half write ignored", out_a, 1'b1);
        run_to(n0 + 43);
        check("R8 out_a low with reloaded 9", out_a, 1'b0);
        run_to(n0 + 50);
        ref_in = 1'b1;
        run_to(n0 + 55);
        check("R8 out_a before reloaded 2", out_a, 1'b0);
        run_to(n0 + 56);
        check("R8 out_a high with reloaded 2", out_a, 1'b1);
        rst = 1'b1;
        tick();
        tick();
        check("R1 out_a cleared by reset", out_a, 1'b0);

        // R10: delay beyond 16 bits
        do_reset();
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd66000);
        wr(2'd0, 32'd1);
        tick();
        n0 = nk;
        ref_in = 1'b1;
        run_to(n0 + 4);
        check("R10 out_a with zero delay", out_a, 1'b1);
        run_to(n0 + 66003);
        check("R10 out_b before 66000 delay", out_b, 1'b0);
        run_to(n0 + 66004);
        check("R10 out_b at 66000 delay", out_b, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule